// File: doc/BRIEF.md
# Dual Masked I2C Slave Address Matcher

This block sits behind an I2C bus framer in a target-side controller. The framer hands it every received byte with a strobe and says whether the byte is the first one after a START (or repeated START) or a later one. The block decides whether this device is being addressed. It holds two programmable 10-bit target addresses, each paired with a per-bit don't-care mask. It can also answer the general call address. It works in a 7-bit addressing mode or in a two-byte 10-bit mode.

When a match is found, the block produces a one-cycle match strobe. With the strobe it reports which address slots hit, whether the general call hit, and the direction bit of the transfer. Each slot also has a sticky hit flag, which software clears by writing a 1. A selected status and a read-request status stay set until the next START or STOP. Shifting the bus lines and driving the ACK are done elsewhere.

Top module: `i2c_addr_match`

## Requirements
- R1: In 7-bit mode (`ten_bit_en`=0), a first byte is compared as follows: byte bits [7:1] against slot address bits [6:0], with byte bit 0 taken as the direction (1 = read). On a hit, `match_pulse`, `match_id` and `rw_bit` show the result in the clock cycle after the strobe edge. Non-first bytes never match in this mode.
- R2: A mask bit of 1 makes the corresponding address bit don't-care. A mask bit of 0 requires equality.
- R3: In 7-bit mode, a slot whose address bits [9:7] are not all zero never matches.
- R4: A slot whose address register is zero never matches, even when its mask is all ones.
- R5: In 10-bit mode, a first byte of the form 11110AAX arms a slot only if AA equals the slot's address bits [9:8] under its mask. A first byte does not raise `match_pulse` by itself, and a first byte without the 11110 prefix arms nothing.
- R6: In 10-bit mode, an armed slot matches when the next non-first byte equals the slot's address bits [7:0] under its mask. `rw_bit` reports the X bit of the first byte. The armed state lasts for one following byte only.
- R7: The first byte 0x00 is a general call. It raises `match_pulse` with `gcall_hit`=1 and `rw_bit`=0, but only while `gcall_en` is 1.
- R8: When both slots match the same byte, both bits of `match_id` are 1 and `match_pulse` is high for a single cycle.
- R9: `hit_flags[i]` is set when slot i matches and stays set until `flag_clr[i]` is 1. A new hit in the same cycle as a clear leaves the flag set.
- R10: Any match sets `slave_sel`. `slave_read` takes the direction bit of that match. Both return to 0 the cycle after `bus_start` or `bus_stop`.
- R11: `bus_start` or `bus_stop` discards an armed 10-bit first byte. A byte strobed in the same cycle as either of them is ignored.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| byte_is_first | input | 1 | 1 = first byte after START/repeated START |
| bus_start | input | 1 | START or repeated START seen |
| bus_stop | input | 1 | STOP seen |
| ten_bit_en | input | 1 | 1 = 10-bit addressing |
| gcall_en | input | 1 | General call answer enable |
| addr_cfg | input | NUM_ADDR*10 (20) | Slot addresses, slot i at bits [10i+9:10i] |
| mask_cfg | input | NUM_ADDR*10 (20) | Slot don't-care masks, same layout |
| flag_clr | input | NUM_ADDR (2) | Write-1-to-clear pulses for hit_flags |
| match_pulse | output | 1 | One-cycle match strobe |
| match_id | output | NUM_ADDR (2) | Slots that hit, valid with match_pulse |
| gcall_hit | output | 1 | General call hit, valid with match_pulse |
| rw_bit | output | 1 | Direction of the latest match, 1 = read |
| hit_flags | output | NUM_ADDR (2) | Sticky per-slot hit flags |
| slave_sel | output | 1 | Device selected since last START/STOP |
| slave_read | output | 1 | Selected for a read |

## Verification
Two things can land in the same cycle: a hardware set of a sticky hit flag and a software clear of that same flag. A START or STOP can also arrive together with a byte strobe. The bench provokes the first case by driving `flag_clr` in the very cycle a matching byte is strobed, and then expects the flag to remain 1. It provokes the second by strobing a 10-bit first byte together with `bus_start`. It then expects no strobe and no match on the following second byte. A scoreboard queue holds the expected result for each byte. Any `match_pulse` that has no queued entry is reported as a failure.

// File: rtl/i2c_amatch_pkg.sv
package i2c_amatch_pkg;
   localparam int ADDR_W = 10;
   localparam int BYTE_W = 8;
   localparam int MAX_SLOTS = 8;
   localparam logic [4:0] TEN_PREFIX = 5'b11110;
   localparam logic [BYTE_W-1:0] GCALL_BYTE = '0;
endpackage

// File: rtl/amatch_slot.sv
module amatch_slot
   import i2c_amatch_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ten_bit_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] mask,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              byte_is_first,
   input  logic              seq_clr,
   output logic              hit
);
   logic [ADDR_W-1:0] care;
   logic              slot_live;
   logic              armed_q;
   logic              arm_now;
   logic              hit7;
   logic              hit10;
   logic              take;

   assign care      = ~mask;
   assign slot_live = (addr != '0);
   assign take      = byte_vld && !seq_clr;

   // 7-bit compare: byte[7:1] vs addr[6:0]
   assign hit7 = byte_is_first && slot_live && (addr[9:7] == 3'b000) &&
                 (((rx_byte[7:1] ^ addr[6:0]) & care[6:0]) == '0);

   // 10-bit header byte: prefix plus AA vs addr[9:8]
   assign arm_now = byte_is_first && slot_live && (rx_byte[7:3] == TEN_PREFIX) &&
                    (((rx_byte[2:1] ^ addr[9:8]) & care[9:8]) == '0);

   // 10-bit low byte after an armed header
   assign hit10 = !byte_is_first && armed_q &&
                  (((rx_byte ^ addr[7:0]) & care[7:0]) == '0);

   assign hit = take && (ten_bit_en ? hit10 : hit7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (seq_clr) begin
         armed_q <= 1'b0;
      end else if (byte_vld) begin
         armed_q <= ten_bit_en && arm_now;
      end
   end
endmodule

// File: rtl/amatch_status.sv
module amatch_status #(
   parameter int NUM_ADDR = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_ADDR-1:0] slot_hit,
   input  logic                gc_now,
   input  logic                rw_now,
   input  logic                seq_clr,
   input  logic [NUM_ADDR-1:0] flag_clr,
   output logic                match_pulse,
   output logic [NUM_ADDR-1:0] match_id,
   output logic                gcall_hit,
   output logic                rw_bit,
   output logic [NUM_ADDR-1:0] hit_flags,
   output logic                slave_sel,
   output logic                slave_read
);
   logic any_hit;
   assign any_hit = (|slot_hit) || gc_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_pulse <= 1'b0;
         match_id    <= '0;
         gcall_hit   <= 1'b0;
         rw_bit      <= 1'b0;
      end else begin
         match_pulse <= any_hit;
         match_id    <= slot_hit;
         gcall_hit   <= gc_now;
         if (any_hit) begin
            rw_bit <= rw_now;
         end
      end
   end

   for (genvar i = 0; i < NUM_ADDR; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hit_flags[i] <= 1'b0;
         end else if (slot_hit[i]) begin
            hit_flags[i] <= 1'b1;
         end else if (flag_clr[i]) begin
            hit_flags[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slave_sel  <= 1'b0;
         slave_read <= 1'b0;
      end else if (seq_clr) begin
         slave_sel  <= 1'b0;
         slave_read <= 1'b0;
      end else if (any_hit) begin
         slave_sel  <= 1'b1;
         slave_read <= rw_now;
      end
   end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
   import i2c_amatch_pkg::*;
#(
   parameter int NUM_ADDR = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       byte_vld,
   input  logic [BYTE_W-1:0]          rx_byte,
   input  logic                       byte_is_first,
   input  logic                       bus_start,
   input  logic                       bus_stop,
   input  logic                       ten_bit_en,
   input  logic                       gcall_en,
   input  logic [NUM_ADDR*ADDR_W-1:0] addr_cfg,
   input  logic [NUM_ADDR*ADDR_W-1:0] mask_cfg,
   input  logic [NUM_ADDR-1:0]        flag_clr,
   output logic                       match_pulse,
   output logic [NUM_ADDR-1:0]        match_id,
   output logic                       gcall_hit,
   output logic                       rw_bit,
   output logic [NUM_ADDR-1:0]        hit_flags,
   output logic                       slave_sel,
   output logic                       slave_read
);
   if (NUM_ADDR < 1 || NUM_ADDR > MAX_SLOTS) begin : g_bad_cfg
      $error("i2c_addr_match: NUM_ADDR out of range");
   end

   logic                seq_clr;
   logic [NUM_ADDR-1:0] slot_hit;
   logic                gc_now;
   logic                rw_hdr_q;
   logic                rw_now;

   assign seq_clr = bus_start || bus_stop;

   for (genvar i = 0; i < NUM_ADDR; i++) begin : g_slot
      amatch_slot u_slot (
         .clk           (clk),
         .rst_n         (rst_n),
         .ten_bit_en    (ten_bit_en),
         .addr          (addr_cfg[i*ADDR_W +: ADDR_W]),
         .mask          (mask_cfg[i*ADDR_W +: ADDR_W]),
         .byte_vld      (byte_vld),
         .rx_byte       (rx_byte),
         .byte_is_first (byte_is_first),
         .seq_clr       (seq_clr),
         .hit           (slot_hit[i])
      );
   end

   assign gc_now = byte_vld && !seq_clr && gcall_en && byte_is_first &&
                   (rx_byte == GCALL_BYTE);

   // direction of a 10-bit transfer lives in the header byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rw_hdr_q <= 1'b0;
      end else if (byte_vld && byte_is_first && !seq_clr &&
                   rx_byte[7:3] == TEN_PREFIX) begin
         rw_hdr_q <= rx_byte[0];
      end
   end

   assign rw_now = (ten_bit_en && !byte_is_first) ? rw_hdr_q : rx_byte[0];

   amatch_status #(.NUM_ADDR(NUM_ADDR)) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot_hit    (slot_hit),
      .gc_now      (gc_now),
      .rw_now      (rw_now),
      .seq_clr     (seq_clr),
      .flag_clr    (flag_clr),
      .match_pulse (match_pulse),
      .match_id    (match_id),
      .gcall_hit   (gcall_hit),
      .rw_bit      (rw_bit),
      .hit_flags   (hit_flags),
      .slave_sel   (slave_sel),
      .slave_read  (slave_read)
   );
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk #(
   parameter int NUM_ADDR = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                byte_vld,
   input logic                byte_is_first,
   input logic                bus_start,
   input logic                bus_stop,
   input logic                ten_bit_en,
   input logic                gcall_en,
   input logic                match_pulse,
   input logic [NUM_ADDR-1:0] match_id,
   input logic                gcall_hit,
   input logic [NUM_ADDR-1:0] hit_flags,
   input logic                slave_sel,
   input logic                slave_read
);
   // R1
   match_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> $past(byte_vld));

   // R6
   ten_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_pulse && !gcall_hit && $past(ten_bit_en)) |-> !$past(byte_is_first));

   // R7
   gcall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gcall_hit |-> $past(gcall_en));

   // R10
   read_implies_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slave_read |-> slave_sel);

   // R11
   seq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_start || bus_stop) |-> (!slave_sel && !match_pulse));

   for (genvar i = 0; i < NUM_ADDR; i++) begin : g_flag_chk
      // R9
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (match_pulse && match_id[i]) |-> hit_flags[i]);
      // R9
      flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(hit_flags[i]) |-> (match_pulse && match_id[i]));
   end
endmodule

bind i2c_addr_match i2c_addr_match_chk #(.NUM_ADDR(NUM_ADDR)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .byte_vld      (byte_vld),
   .byte_is_first (byte_is_first),
   .bus_start     (bus_start),
   .bus_stop      (bus_stop),
   .ten_bit_en    (ten_bit_en),
   .gcall_en      (gcall_en),
   .match_pulse   (match_pulse),
   .match_id      (match_id),
   .gcall_hit     (gcall_hit),
   .hit_flags     (hit_flags),
   .slave_sel     (slave_sel),
   .slave_read    (slave_read)
);

// File: tb/i2c_addr_match_bench.sv
`timescale 1ns/1ps
module i2c_addr_match_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_vld = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        byte_is_first = 1'b0;
   logic        bus_start = 1'b0;
   logic        bus_stop = 1'b0;
   logic        ten_bit_en = 1'b0;
   logic        gcall_en = 1'b0;
   logic [19:0] addr_cfg = '0;
   logic [19:0] mask_cfg = '0;
   logic [1:0]  flag_clr = '0;
   logic        match_pulse;
   logic [1:0]  match_id;
   logic        gcall_hit;
   logic        rw_bit;
   logic [1:0]  hit_flags;
   logic        slave_sel;
   logic        slave_read;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 1'b0;

   typedef struct {
      int         due;
      bit         p;
      logic [1:0] id;
      bit         gc;
      bit         rw;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   i2c_addr_match u_i2c_addr_match (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .rx_byte(rx_byte),
      .byte_is_first(byte_is_first), .bus_start(bus_start), .bus_stop(bus_stop),
      .ten_bit_en(ten_bit_en), .gcall_en(gcall_en), .addr_cfg(addr_cfg),
      .mask_cfg(mask_cfg), .flag_clr(flag_clr), .match_pulse(match_pulse),
      .match_id(match_id), .gcall_hit(gcall_hit), .rw_bit(rw_bit),
      .hit_flags(hit_flags), .slave_sel(slave_sel), .slave_read(slave_read)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: strobe one byte, queue the expected outcome for the next cycle
   task automatic send(input logic [7:0] b, input bit first, input bit st, input logic [1:0] clr,
                       input bit ep, input logic [1:0] eid, input bit egc, input bit erw,
                       input string tag);
      exp_t e;
      @(negedge clk);
      byte_vld = 1'b1; rx_byte = b; byte_is_first = first; bus_start = st; flag_clr = clr;
      e.due = cyc + 1; e.p = ep; e.id = eid; e.gc = egc; e.rw = erw; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      byte_vld = 1'b0; bus_start = 1'b0; flag_clr = '0;
   endtask

   task automatic bus_evt(input bit st, input bit sp);
      @(negedge clk);
      bus_start = st; bus_stop = sp;
      @(negedge clk);
      bus_start = 1'b0; bus_stop = 1'b0;
   endtask

   task automatic clear(input logic [1:0] m);
      @(negedge clk);
      flag_clr = m;
      @(negedge clk);
      flag_clr = '0;
   endtask

   // monitor: pop and compare when a queued result is due
   always @(negedge clk) begin
      exp_t e;
      if (sb.size() > 0 && sb[0].due == cyc) begin
         e = sb.pop_front();
         chk({e.tag, " pulse"}, {31'b0, match_pulse}, {31'b0, e.p});
         chk({e.tag, " id"}, {30'b0, match_id}, {30'b0, e.id});
         chk({e.tag, " gcall"}, {31'b0, gcall_hit}, {31'b0, e.gc});
         if (e.p) chk({e.tag, " rw"}, {31'b0, rw_bit}, {31'b0, e.rw});
      end else if (rst_n && match_pulse) begin
         total++; bad++;
         $display("FAIL R8 unexpected strobe actual=1 expected=0");
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk("R12 pulse", {31'b0, match_pulse}, 0);
      chk("R12 flags", {30'b0, hit_flags}, 0);
      chk("R12 sel", {30'b0, slave_sel, slave_read}, 0);
      chk("R12 rw", {31'b0, rw_bit}, 0);

      addr_cfg = {10'h030, 10'h050};
      mask_cfg = {10'h003, 10'h000};
      // R1 7-bit write hit on slot 0
      send(8'hA0, 1, 0, 0, 1, 2'b01, 0, 0, "R1 hit");
      chk("R9 flag set", {30'b0, hit_flags}, 2'b01);
      chk("R10 sel", {30'b0, slave_sel, slave_read}, 2'b10);
      // R1 non-first byte ignored
      send(8'hA0, 0, 0, 0, 0, 2'b00, 0, 0, "R1 nonfirst");
      // R2 masked bits
      send(8'h63, 1, 0, 0, 1, 2'b10, 0, 1, "R2 mask lsb");
      chk("R10 read", {30'b0, slave_sel, slave_read}, 2'b11);
      send(8'h64, 1, 0, 0, 1, 2'b10, 0, 0, "R2 mask bit1");
      send(8'h68, 1, 0, 0, 0, 2'b00, 0, 0, "R2 unmasked");
      // R10 stop clears status, R9 flags stay
      bus_evt(0, 1);
      chk("R10 stop", {30'b0, slave_sel, slave_read}, 0);
      chk("R9 sticky", {30'b0, hit_flags}, 2'b11);
      clear(2'b01);
      chk("R9 clear0", {30'b0, hit_flags}, 2'b10);
      clear(2'b10);
      chk("R9 clear1", {30'b0, hit_flags}, 2'b00);
      // R8 both slots on one byte
      addr_cfg = {10'h030, 10'h031};
      send(8'h62, 1, 0, 0, 1, 2'b11, 0, 0, "R8 both");
      chk("R8 flags", {30'b0, hit_flags}, 2'b11);
      // R7 general call
      send(8'h00, 1, 0, 0, 0, 2'b00, 0, 0, "R7 gc off");
      gcall_en = 1'b1;
      send(8'h00, 1, 0, 0, 1, 2'b00, 1, 0, "R7 gc on");
      gcall_en = 1'b0;
      // R4 zero address with full mask
      addr_cfg = {10'h030, 10'h000};
      mask_cfg = {10'h003, 10'h3FF};
      send(8'h00, 1, 0, 0, 0, 2'b00, 0, 0, "R4 zero");
      send(8'h62, 1, 0, 0, 1, 2'b10, 0, 0, "R4 zero slot silent");
      // R3 upper bits set in 7-bit mode
      addr_cfg = {10'h030, 10'h0B1};
      mask_cfg = {10'h003, 10'h000};
      send(8'h62, 1, 0, 0, 1, 2'b10, 0, 0, "R3 upper");
      // R9 set and clear in the same cycle
      clear(2'b11);
      chk("R9 clear all", {30'b0, hit_flags}, 0);
      send(8'h62, 1, 0, 2'b10, 1, 2'b10, 0, 0, "R9 coincide");
      chk("R9 set wins", {30'b0, hit_flags}, 2'b10);

      // 10-bit mode
      ten_bit_en = 1'b1;
      addr_cfg = {10'h1A5, 10'h2A5};
      mask_cfg = {10'h100, 10'h000};
      bus_evt(0, 1);
      send(8'hF5, 1, 0, 0, 0, 2'b00, 0, 0, "R5 header");
      send(8'hA5, 0, 0, 0, 1, 2'b01, 0, 1, "R6 low byte");
      chk("R10 ten sel", {30'b0, slave_sel, slave_read}, 2'b11);
      send(8'hF5, 1, 0, 0, 0, 2'b00, 0, 0, "R5 header2");
      send(8'hA4, 0, 0, 0, 0, 2'b00, 0, 0, "R6 low miss");
      send(8'hA5, 0, 0, 0, 0, 2'b00, 0, 0, "R6 one byte only");
      send(8'hF5, 1, 0, 0, 0, 2'b00, 0, 0, "R11 header");
      bus_evt(1, 0);
      chk("R11 start clr sel", {31'b0, slave_sel}, 0);
      send(8'hA5, 0, 0, 0, 0, 2'b00, 0, 0, "R11 disarmed");
      send(8'hF2, 1, 0, 0, 0, 2'b00, 0, 0, "R5 masked AA");
      send(8'hA5, 0, 0, 0, 1, 2'b10, 0, 0, "R6 slot1 write");
      send(8'h62, 1, 0, 0, 0, 2'b00, 0, 0, "R5 no prefix");
      send(8'hF5, 1, 1, 0, 0, 2'b00, 0, 0, "R11 byte with start");
      send(8'hA5, 0, 0, 0, 0, 2'b00, 0, 0, "R11 not armed");
      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule